// File: doc/BRIEF.md
# Transceiver Power-Mode Controller

This block owns the power-saving control bits of a 10/100 Ethernet transceiver and turns them into enable lines for the analog front end, the receive path, the transmit line drivers and the recovered and transmit clocks. Software sets the bits through register write strobes. The block combines them with the current link speed and a line signal-detect input. Each enable comes from a flop, so a change shows at the outputs one clock after the write or signal-detect edge that caused it.

There are three modes. Full power-down turns off every functional circuit but leaves the management registers readable and writable. Receive power saving shuts the receive path and its clock while the line is quiet, and wakes them when signal detect returns. It applies only at 100 Mb/s. Transmit high impedance floats the transmit drivers and the transmit clock pin and turns on a weak pull-up on that pin. Once set, this bit stays set until reset.

Top module: `phy_pwr_ctl`

## Requirements
- R1: After reset, every control bit reads 0, `pd_out`, `txclk_tri` and `txclk_pullup` are 0, and `afe_en`, `rx_en`, `rx_clk_en`, `tx_drv_en` and `tx_clk_en` are 1.
- R2: A write of 1 to bit 11 at address 0 sets `pd_out`. At the same clock it drops `afe_en`, `rx_en`, `rx_clk_en`, `tx_drv_en` and `tx_clk_en`, one clock after the write.
- R3: While `pd_out` is 1, writes still update the control bits and `rd_data` still returns them.
- R4: When bit 0 at address 16 is 1, `speed_100` is 1 and `sig_det` is 0, `rx_en` and `rx_clk_en` are 0. One clock after `sig_det` rises, both return to 1.
- R5: When `speed_100` is 0, bit 0 at address 16 has no effect on `rx_en` or `rx_clk_en`.
- R6: When bit 12 at address 16 is 1, `tx_drv_en` and `tx_clk_en` are 0 and `txclk_tri` and `txclk_pullup` are 1. The receive enables are unaffected.
- R7: Bit 12 at address 16 cannot be cleared by a write of 0; only reset clears it.
- R8: `ldo_en` is 1 at all times, including power-down.
- R9: Power-down overrides the other two modes. Clearing bit 11 restores every enable to the value the remaining bits and inputs imply.
- R10: `rd_data` returns bit 11 at address 0, and bits 0 and 12 at address 16. All other bits and addresses read 0, and writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read register address |
| rd_data | output | 16 | Read data (combinational) |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| sig_det | input | 1 | Line signal detect |
| pd_out | output | 1 | Chip power-down indication |
| afe_en | output | 1 | Analog front-end enable |
| rx_en | output | 1 | Receive path enable (equalizer, clock recovery) |
| rx_clk_en | output | 1 | Receive clock gate enable |
| tx_drv_en | output | 1 | Transmit line driver enable |
| tx_clk_en | output | 1 | Transmit clock gate enable |
| txclk_tri | output | 1 | Transmit clock pin high impedance |
| txclk_pullup | output | 1 | Weak pull-up on transmit clock pin |
| ldo_en | output | 1 | On-chip regulator enable |

## Verification
The bench uses the default parameters: 16-bit data, 5-bit addresses, registers at 0 and 16, and bits 11, 0 and 12. With these values every reachable combination of the three mode bits, the speed and signal detect can be driven through a few register writes. The bench also places a read of the written-back bits right after each power-down entry. Because reset is the only way to clear the transmit bit, each table row starts from a reset.

// File: rtl/phy_pwr_ctl.sv
module phy_pwr_ctl #(
  parameter int AW        = 5,
  parameter int DW        = 16,
  parameter int CTRL_ADDR = 0,
  parameter int PWR_ADDR  = 16,
  parameter int PD_BIT    = 11,
  parameter int RXPM_BIT  = 0,
  parameter int TXZ_BIT   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          speed_100,
  input  logic          sig_det,
  output logic          pd_out,
  output logic          afe_en,
  output logic          rx_en,
  output logic          rx_clk_en,
  output logic          tx_drv_en,
  output logic          tx_clk_en,
  output logic          txclk_tri,
  output logic          txclk_pullup,
  output logic          ldo_en
);
  localparam logic [AW-1:0] CA = AW'(CTRL_ADDR);
  localparam logic [AW-1:0] PA = AW'(PWR_ADDR);

  logic pd_q, rxpm_q, txz_q;
  logic pd_d, rxpm_d, txz_d;
  logic quiet;

  wire wr_ctrl = wr_en && (wr_addr == CA);
  wire wr_pwr  = wr_en && (wr_addr == PA);

  assign pd_d   = wr_ctrl ? wr_data[PD_BIT]   : pd_q;
  assign rxpm_d = wr_pwr  ? wr_data[RXPM_BIT] : rxpm_q;
  assign txz_d  = txz_q | (wr_pwr & wr_data[TXZ_BIT]);
  assign quiet  = rxpm_d & speed_100 & ~sig_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q         <= 1'b0;
      rxpm_q       <= 1'b0;
      txz_q        <= 1'b0;
      pd_out       <= 1'b0;
      afe_en       <= 1'b1;
      rx_en        <= 1'b1;
      rx_clk_en    <= 1'b1;
      tx_drv_en    <= 1'b1;
      tx_clk_en    <= 1'b1;
      txclk_tri    <= 1'b0;
      txclk_pullup <= 1'b0;
    end else begin
      pd_q         <= pd_d;
      rxpm_q       <= rxpm_d;
      txz_q        <= txz_d;
      pd_out       <= pd_d;
      afe_en       <= ~pd_d;
      rx_en        <= ~pd_d & ~quiet;
      rx_clk_en    <= ~pd_d & ~quiet;
      tx_drv_en    <= ~pd_d & ~txz_d;
      tx_clk_en    <= ~pd_d & ~txz_d;
      txclk_tri    <= txz_d;
      txclk_pullup <= txz_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CA) begin
      rd_data[PD_BIT] = pd_q;
    end else if (rd_addr == PA) begin
      rd_data[RXPM_BIT] = rxpm_q;
      rd_data[TXZ_BIT]  = txz_q;
    end
  end

  assign ldo_en = 1'b1;
endmodule

// File: rtl/phy_pwr_ctl_chk.sv
module phy_pwr_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic speed_100,
  input logic pd_out,
  input logic afe_en,
  input logic rx_en,
  input logic rx_clk_en,
  input logic tx_drv_en,
  input logic txclk_tri,
  input logic txclk_pullup,
  input logic ldo_en
);
  // R2
  pd_gates_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_out |-> (!afe_en && !rx_en && !rx_clk_en && !tx_drv_en));
  // R4
  rxclk_follows_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clk_en == rx_en);
  // R5
  slow_no_rxpm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(speed_100) && !pd_out) |-> rx_en);
  // R6
  tx_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txclk_tri |-> (!tx_drv_en && txclk_pullup));
  // R7
  tx_hiz_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txclk_tri |=> txclk_tri);
  // R8
  ldo_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_out |-> ldo_en);
endmodule

bind phy_pwr_ctl phy_pwr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .pd_out(pd_out),
  .afe_en(afe_en), .rx_en(rx_en), .rx_clk_en(rx_clk_en), .tx_drv_en(tx_drv_en),
  .txclk_tri(txclk_tri), .txclk_pullup(txclk_pullup), .ldo_en(ldo_en)
);

// File: tb/phy_pwr_ctl_test.sv
module phy_pwr_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic speed_100 = 1'b1, sig_det = 1'b0;
  logic pd_out, afe_en, rx_en, rx_clk_en, tx_drv_en, tx_clk_en, txclk_tri, txclk_pullup, ldo_en;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  phy_pwr_ctl uut (.*);

  // inputs {pd, rxpm, txz, spd, sd} -> outputs {pd, afe, rx, rxclk, txd, txclk, tri, pull}
  localparam logic [12:0] VEC [8] = '{
    {5'b00010, 8'b0111_1100},
    {5'b01010, 8'b0100_1100},
    {5'b01011, 8'b0111_1100},
    {5'b01000, 8'b0111_1100},
    {5'b00110, 8'b0111_0011},
    {5'b10011, 8'b1000_0000},
    {5'b11110, 8'b1000_0011},
    {5'b01110, 8'b0100_0011}
  };

  function automatic logic [7:0] outs();
    return {pd_out, afe_en, rx_en, rx_clk_en, tx_drv_en, tx_clk_en, txclk_tri, txclk_pullup};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 outputs", {8'h0, outs()}, 16'h007C);
    rd_addr = 5'd0;  #1 chk("R1 reg0", rd_data, 16'h0000);
    rd_addr = 5'd16; #1 chk("R1 reg16", rd_data, 16'h0000);
    chk("R8 ldo", {15'h0, ldo_en}, 16'h1);

    // R2 R4 R5 R6 R9 table
    for (int i = 0; i < 8; i++) begin
      do_reset();
      speed_100 = VEC[i][9]; sig_det = VEC[i][8];
      wr(5'd16, {3'b0, VEC[i][10], 11'b0, VEC[i][11]});
      wr(5'd0, {4'b0, VEC[i][12], 11'b0});
      chk($sformatf("R2 R4 R5 R6 R9 row %0d", i), {8'h0, outs()}, {8'h0, VEC[i][7:0]});
    end

    // R3 R10 R8: management works in power-down, readback positions
    do_reset();
    speed_100 = 1'b1; sig_det = 1'b1;
    wr(5'd0, 16'hFFFF);
    chk("R2 pd", {15'h0, pd_out}, 16'h1);
    chk("R8 ldo in pd", {15'h0, ldo_en}, 16'h1);
    rd_addr = 5'd0; #1 chk("R10 reg0 only bit11", rd_data, 16'h0800);
    wr(5'd16, 16'h0001);
    rd_addr = 5'd16; #1 chk("R3 write in pd", rd_data, 16'h0001);
    wr(5'd5, 16'hFFFF);
    rd_addr = 5'd5; #1 chk("R10 other addr", rd_data, 16'h0000);
    rd_addr = 5'd16; #1 chk("R10 other addr no effect", rd_data, 16'h0001);

    // R9 leave pd with rxpm on at 100M, line quiet
    sig_det = 1'b0;
    wr(5'd0, 16'h0000);
    chk("R9 leave pd", {8'h0, outs()}, 16'h004C);
    // R4 wake one clock after sig_det rises
    sig_det = 1'b1;
    #1 chk("R4 before edge", {15'h0, rx_en}, 16'h0);
    @(negedge clk);
    chk("R4 wake", {14'h0, rx_en, rx_clk_en}, 16'h3);
    sig_det = 1'b0;
    @(negedge clk);
    chk("R4 sleep again", {14'h0, rx_en, rx_clk_en}, 16'h0);
    // R5 drop to 10M
    speed_100 = 1'b0;
    @(negedge clk);
    chk("R5 10M no effect", {14'h0, rx_en, rx_clk_en}, 16'h3);

    // R7 sticky transmit hiz
    wr(5'd16, 16'h1000);
    chk("R6 hiz on", {8'h0, outs()}, 16'h0073);
    wr(5'd16, 16'h0000);
    rd_addr = 5'd16; #1 chk("R7 write 0 ignored", rd_data, 16'h1000);
    chk("R7 tri kept", {14'h0, txclk_tri, tx_drv_en}, 16'h2);
    do_reset();
    chk("R7 reset clears", {14'h0, txclk_tri, tx_drv_en}, 16'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule